// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller sits between a processor core and an 8-bit multiplexed external memory bus. It runs three kinds of access: code fetches, data reads and data writes. Each access moves across a low port that carries first an address byte and then a data byte, a high port, an address latch strobe and three active-low strobes: one for code output-enable, one for data read and one for data write. External latches capture the low address byte and, for data accesses, a page byte while the latch strobe is high. This gives data accesses a 24-bit space. A system without a page latch sees plain 16-bit addressing.

The core starts an access with a one-cycle start pulse. It gives a 24-bit address, a write byte and a 2-bit kind code. When the access finishes, the controller returns a one-cycle done pulse, and read data is valid with it. An external-access pin is sampled while reset is held. Its value tells the core whether execution begins in external code space at address 0.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and after it, with no request, all strobes are high, the latch strobe is low, the low port is not driven, busy and done are low.
- R2: The boot flag equals the inverse of the external-access pin, sampled while reset is low. It holds that value after reset, even if the pin then changes.
- R3: In the first cycle of every access, the latch strobe is high for exactly one cycle and the low port is driven with address bits [7:0].
- R4: Kind 2'b00 is a code fetch. The high port carries address bits [15:8] for the whole access, including the latch phase. Address bits [23:16] are ignored. The code output-enable strobe is the only strobe that goes low.
- R5: Kinds 2'b01 and 2'b11 are data reads and kind 2'b10 is a data write. During the latch phase the high port carries address bits [23:16]. After that it carries bits [15:8].
- R6: While the read or code strobe is low, the low port is not driven. Read data is the low-port value captured on the last clock edge before that strobe rises.
- R7: A write drives the write byte on the low port from the cycle after the latch phase until one cycle after the write strobe rises. The write strobe is low for exactly two cycles.
- R8: At most one of the three strobes is low in any cycle.
- R9: Done is a one-cycle pulse in the fifth cycle after the edge that accepts the start pulse. Busy is high from the accept edge until done ends.
- R10: A start pulse that arrives while an access is in progress is ignored and does not start a later access.
- R11: With no page latch fitted, data accesses that differ only in bits [23:16] reach the same external byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_acc_pin | input | 1 | External-access pin, sampled during reset |
| boot_ext | output | 1 | High when execution starts in external code space |
| req_start | input | 1 | One-cycle access start |
| req_kind | input | 2 | 00 code fetch, 01/11 data read, 10 data write |
| req_addr | input | 24 | Access address |
| req_wdata | input | 8 | Write byte |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read or fetch result |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 1 | Low port drive enable |
| p0_in | input | 8 | Low port input value |
| p2_out | output | 8 | High port output value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code output-enable strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Code fetches are run with nonzero page bits, so that the latched high-port value shows whether page bits leak into code addressing. Writes and reads go to two addresses that differ only in the page byte, which shows whether the page byte reaches the external latch. A read of a location that was never written tells captured data apart from stale data. The same write and read are then repeated with the bench's page latch removed. Other checks cover both levels of the external-access pin and a start pulse issued in the middle of an access.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int PORT_W = 8,
  localparam int ADDR_W = 3 * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_acc_pin,
  output logic              boot_ext,
  input  logic              req_start,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PORT_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              req_done,
  output logic [PORT_W-1:0] req_rdata,
  output logic [PORT_W-1:0] p0_out,
  output logic              p0_oe,
  input  logic [PORT_W-1:0] p0_in,
  output logic [PORT_W-1:0] p2_out,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LATCH, ST_SETUP, ST_STROBE, ST_SAMPLE, ST_FINISH
  } phase_t;

  phase_t            st;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PORT_W-1:0] wdata_q;
  logic [PORT_W-1:0] rdata_q;
  logic              boot_q;

  wire is_code  = (kind_q == 2'b00);
  wire is_write = (kind_q == 2'b10);
  wire strobing = (st == ST_STROBE) || (st == ST_SAMPLE);
  wire wr_drive = is_write && (st == ST_SETUP || strobing || st == ST_FINISH);

  wire [PORT_W-1:0] a_lo   = addr_q[PORT_W-1:0];
  wire [PORT_W-1:0] a_hi   = addr_q[2*PORT_W-1:PORT_W];
  wire [PORT_W-1:0] a_page = addr_q[ADDR_W-1:2*PORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= ~ext_acc_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind_q  <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_start) begin
          st      <= ST_LATCH;
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        ST_LATCH:  st <= ST_SETUP;
        ST_SETUP:  st <= ST_STROBE;
        ST_STROBE: st <= ST_SAMPLE;
        ST_SAMPLE: begin
          st <= ST_FINISH;
          if (!is_write) rdata_q <= p0_in;
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign boot_ext  = boot_q;
  assign req_busy  = (st != ST_IDLE);
  assign req_done  = (st == ST_FINISH);
  assign req_rdata = rdata_q;

  assign ale    = (st == ST_LATCH);
  assign psen_n = !(strobing && is_code);
  assign rd_n   = !(strobing && !is_code && !is_write);
  assign wr_n   = !(strobing && is_write);

  assign p0_oe  = ale || wr_drive;
  assign p0_out = ale ? a_lo : (wr_drive ? wdata_q : '0);
  assign p2_out = (st == ST_IDLE) ? '0 : ((ale && !is_code) ? a_page : a_hi);

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(parameter int PORT_W = 8) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              p0_oe,
  input logic [PORT_W-1:0] p0_out,
  input logic              req_done,
  input logic              req_busy
);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  // R6
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe);

  // R3
  ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> p0_oe);

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (!req_done && !req_busy));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .p0_oe(p0_oe), .p0_out(p0_out), .req_done(req_done),
  .req_busy(req_busy)
);

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;
  localparam real CLK_NS = 4.0;
  localparam int NV = 11;
  // {kind, addr, wdata, expected}
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 24'h001234, 8'h00, 8'h26},
    {2'b00, 24'h00FF01, 8'h00, 8'hFE},
    {2'b00, 24'h5A0102, 8'h00, 8'h03},
    {2'b10, 24'h123456, 8'hC3, 8'h00},
    {2'b01, 24'h123456, 8'h00, 8'hC3},
    {2'b10, 24'h7F3456, 8'h3C, 8'h00},
    {2'b01, 24'h123456, 8'h00, 8'hC3},
    {2'b01, 24'h7F3456, 8'h00, 8'h3C},
    {2'b01, 24'h010000, 8'h00, 8'hA4},
    {2'b11, 24'h010000, 8'h00, 8'hA4},
    {2'b00, 24'h00AA55, 8'h00, 8'hFF}
  };

  logic clk = 0, rst_n = 0, ext_acc_pin = 1;
  logic req_start = 0;
  logic [1:0] req_kind = 0;
  logic [23:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic boot_ext, req_busy, req_done;
  logic [7:0] req_rdata, p0_out, p2_out, p0_in;
  logic p0_oe, ale, psen_n, rd_n, wr_n;

  int checks = 0, errors = 0;
  logic [7:0] lat_lo = 0, lat_page = 0;
  logic page_fitted = 1;
  int ale_cycles = 0, wr_low = 0, wr_events = 0, excl_bad = 0, float_bad = 0;
  logic [7:0] dmem [int unsigned];

  always #(CLK_NS/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_acc_pin(ext_acc_pin), .boot_ext(boot_ext),
    .req_start(req_start), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_busy(req_busy), .req_done(req_done),
    .req_rdata(req_rdata), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
    .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic int unsigned data_addr();
    return page_fitted ? {8'h0, lat_page, p2_out, lat_lo} : {16'h0, p2_out, lat_lo};
  endfunction

  function automatic logic [7:0] data_byte(int unsigned a);
    if (dmem.exists(a)) return dmem[a];
    return a[23:16] ^ a[15:8] ^ a[7:0] ^ 8'hA5;
  endfunction

  always_comb begin
    if (!psen_n) p0_in = p2_out ^ lat_lo;
    else if (!rd_n) p0_in = data_byte(data_addr());
    else p0_in = 8'h00;
  end

  always @(negedge clk) begin
    if (ale) begin
      lat_lo = p0_out;
      lat_page = p2_out;
      ale_cycles++;
    end
    if (!wr_n) begin
      wr_low++;
      dmem[data_addr()] = p0_out;
    end
    if ((!psen_n + !rd_n + !wr_n) > 1) excl_bad++;
    if ((!psen_n || !rd_n) && p0_oe) float_bad++;
  end

  always @(posedge wr_n) if (rst_n) wr_events++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] k, input logic [23:0] a,
                        input logic [7:0] wd, output logic [7:0] rd, output int cyc);
    @(negedge clk);
    req_kind = k; req_addr = a; req_wdata = wd; req_start = 1;
    wr_low = 0;
    @(negedge clk);
    req_start = 0;
    cyc = 1;
    while (!req_done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    rd = req_rdata;
  endtask

  task automatic do_reset(logic pin);
    rst_n = 0;
    ext_acc_pin = pin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cyc;
    int a0;
    int w0;

    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 strobes", {psen_n, rd_n, wr_n, ale}, 4'b1110);
    check("R1 idle", {p0_oe, req_busy, req_done}, 3'b000);
    do_reset(1'b1);
    check("R2 pin high", boot_ext, 1'b0);
    ext_acc_pin = 0;
    repeat (2) @(negedge clk);
    check("R2 holds", boot_ext, 1'b0);
    check("R1 after reset", {psen_n, rd_n, wr_n, ale, p0_oe, req_busy}, 6'b111000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [23:0] a;
      logic [7:0] wd, ex;
      {k, a, wd, ex} = VEC[i];
      a0 = ale_cycles;
      access(k, a, wd, rd, cyc);
      check("R9 latency", cyc, 5);
      check("R3 ale one cycle", ale_cycles - a0, 1);
      check("R3 low addr", lat_lo, a[7:0]);
      if (k == 2'b00) check("R4 p2 at latch", lat_page, a[15:8]);
      else check("R5 page at latch", lat_page, a[23:16]);
      if (k == 2'b10) check("R7 wr low cycles", wr_low, 2);
      else check("R6 read data", rd, ex);
      @(negedge clk);
      check("R9 done single", {req_done, req_busy}, 2'b00);
    end

    // R10 start while busy ignored
    a0 = ale_cycles;
    w0 = wr_events;
    fork
      access(2'b01, 24'h000010, 8'h00, rd, cyc);
      begin
        repeat (3) @(negedge clk);
        req_kind = 2'b10; req_addr = 24'h000020; req_wdata = 8'h77; req_start = 1;
        @(negedge clk);
        req_start = 0;
      end
    join
    repeat (6) @(negedge clk);
    check("R10 single access", ale_cycles - a0, 1);
    check("R10 no write", wr_events - w0, 0);
    check("R10 idle", req_busy, 1'b0);

    // R11 no page latch
    page_fitted = 0;
    access(2'b10, 24'h992222, 8'h11, rd, cyc);
    access(2'b01, 24'h002222, 8'h00, rd, cyc);
    check("R11 alias low page", rd, 8'h11);
    access(2'b01, 24'h552222, 8'h00, rd, cyc);
    check("R11 alias other page", rd, 8'h11);
    page_fitted = 1;

    // R8 / R6 monitors
    check("R8 strobe overlap", excl_bad, 0);
    check("R6 port float", float_bad, 0);

    do_reset(1'b0);
    check("R2 pin low", boot_ext, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule